// File: doc/BRIEF.md
# EEPROM Write-Status Read Path

This block sits in the read path of a byte-wide parallel EEPROM, between the self-timed write engine and the bus. While the write engine reports busy, the block replaces array read data with a status byte. The status byte carries two completion indicators at once, so the host can poll in either way. The most significant bit is the inverse of the same bit of the byte most recently latched for writing. The next bit down flips on every read strobe. The remaining low bits repeat the latched byte. When busy drops, reads return array data on every bit and the flipping bit stops.

The bus is driven only during a valid read: chip enable low, output enable low and write enable high. At all other times the output-enable flag is low and the data lines are forced to zero. A rising edge of busy marks a new write cycle. That edge clears the flipping bit, so the first status read of every cycle returns a known value. The host may begin polling on that first read.

Top module: `eeprom_wr_poll`

## Requirements
- R1: `bus_oe_o` is 1 exactly when `ce_ni` is 0, `oe_ni` is 0 and `we_ni` is 1, in the same cycle, with no register on the path.
- R2: When `bus_oe_o` is 0, `bus_data_o` is all zeros.
- R3: When `busy_i` is 0 and the bus is enabled, `bus_data_o` equals `array_data_i` on every bit.
- R4: When `busy_i` is 1 and the bus is enabled, bit 7 of `bus_data_o` is the inverse of bit 7 of `last_data_i`.
- R5: While `busy_i` stays 1, bit 6 of `bus_data_o` takes the opposite value after each cycle in which `rd_strobe_i` was 1. It keeps its value after a cycle with `rd_strobe_i` at 0.
- R6: In the first cycle with `busy_i` at 1 after a cycle with `busy_i` at 0, bit 6 of `bus_data_o` is 0, whatever value it had before.
- R7: When `busy_i` is 1 and the bus is enabled, bits 5 to 0 of `bus_data_o` equal bits 5 to 0 of `last_data_i`.
- R8: Read strobes while `busy_i` is 0 do not change the flipping bit. Such reads return array bit 6 on bus bit 6.
- R9: After `rst_ni` is released, the flipping bit is 0, and `busy_i` at 1 in the first cycle counts as the start of a new write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Self-timed write in progress |
| rd_strobe_i | input | 1 | One-cycle pulse per host read access |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| last_data_i | input | 8 | Byte most recently latched for writing |
| array_data_i | input | 8 | Data read from the array |
| bus_data_o | output | 8 | Data presented to the bus |
| bus_oe_o | output | 1 | Bus driver enable |

## Verification
A flipping bit left in the wrong state shows up at the first status read after a busy edge. Bit 6 reads 1 where 0 is expected, or it repeats a value across two strobed reads. A wrong busy history makes the first read of a cycle inherit the previous phase, and it does so in the same cycle. A wrong select shows within one read: array bits appear during busy, or bit 7 fails to invert. The stimulus strobes reads with and without busy, inserts gaps with no strobe, and restarts write cycles from both flip states.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/wsp_toggle.sv
module wsp_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_strobe_i,
  output logic start_o,
  output logic tog_o
);
  logic busy_q, tog_q;

  assign start_o = busy_i & ~busy_q;
  // a new cycle masks the stale phase for its first read
  assign tog_o   = start_o ? 1'b0 : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_i && rd_strobe_i) tog_q <= ~tog_o;
      else if (start_o)          tog_q <= 1'b0;
    end
  end

  assert_start_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !tog_o);
  assert_tog_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i && rd_strobe_i) && busy_i && !start_o) |-> (tog_o != $past(tog_o)));
  assert_tog_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rd_strobe_i) && busy_i && !start_o) |-> $stable(tog_o));
  assert_idle_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!busy_i) && !busy_i) |-> $stable(tog_q));
endmodule

// File: rtl/wsp_mux.sv
module wsp_mux #(
  parameter int DW = 8
) (
  input  wsp_pkg::rd_src_e src_i,
  input  logic             tog_i,
  input  logic [DW-1:0]    last_data_i,
  input  logic [DW-1:0]    array_data_i,
  output logic [DW-1:0]    data_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] status_w;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status_w[b] = ~last_data_i[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_w[b] = tog_i;
    end else begin : g_pass
      assign status_w[b] = last_data_i[b];
    end
  end

  assign data_o = (src_i == wsp_pkg::SRC_STATUS) ? status_w : array_data_i;
endmodule

// File: rtl/wsp_bus_gate.sv
module wsp_bus_gate #(
  parameter int DW = 8
) (
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  assign oe_o   = ~ce_ni & ~oe_ni & we_ni;
  assign data_o = oe_o ? data_i : '0;

  always_comb begin
    assert_zero_idle_R2: assert (oe_o || data_o == '0);
  end
endmodule

// File: rtl/eeprom_wr_poll.sv
module eeprom_wr_poll #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          rd_strobe_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_oe_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic             start_w, tog_w;
  logic [DW-1:0]    mux_w;
  wsp_pkg::rd_src_e src_w;

  assign src_w = busy_i ? wsp_pkg::SRC_STATUS : wsp_pkg::SRC_ARRAY;

  wsp_toggle u_toggle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .rd_strobe_i (rd_strobe_i),
    .start_o     (start_w),
    .tog_o       (tog_w)
  );

  wsp_mux #(.DW(DW)) u_mux (
    .src_i        (src_w),
    .tog_i        (tog_w),
    .last_data_i  (last_data_i),
    .array_data_i (array_data_i),
    .data_o       (mux_w)
  );

  wsp_bus_gate #(.DW(DW)) u_gate (
    .ce_ni  (ce_ni),
    .oe_ni  (oe_ni),
    .we_ni  (we_ni),
    .data_i (mux_w),
    .data_o (bus_data_o),
    .oe_o   (bus_oe_o)
  );

  assert_oe_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!ce_ni && !oe_ni && we_ni));
  assert_idle_true_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && !busy_i) |-> (bus_data_o == array_data_i));
  assert_poll_inv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && busy_i) |-> (bus_data_o[POLL_BIT] != last_data_i[POLL_BIT]));
  assert_low_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && busy_i) |-> (bus_data_o[TOG_BIT-1:0] == last_data_i[TOG_BIT-1:0]));
  assert_first_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && start_w) |-> !bus_data_o[TOG_BIT]);
endmodule

// File: tb/eeprom_wr_poll_bench.sv
module eeprom_wr_poll_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, rd = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] last = '0, arr = '0;
  logic [7:0] data;
  logic       oe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  eeprom_wr_poll u_eeprom_wr_poll (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .rd_strobe_i(rd),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .last_data_i(last), .array_data_i(arr),
    .bus_data_o(data), .bus_oe_o(oe)
  );

  // {req, busy, rd, ce_n, oe_n, we_n, last, arr, exp_oe, exp_data}
  localparam logic [33:0] VEC [13] = '{
    {4'd3, 5'b00001, 8'hA5, 8'h3C, 1'b1, 8'h3C}, // R3 idle read
    {4'd6, 5'b11001, 8'hA5, 8'h3C, 1'b1, 8'h25}, // R6 R4 R7 first status read
    {4'd5, 5'b11001, 8'hA5, 8'h3C, 1'b1, 8'h65}, // R5 flipped
    {4'd5, 5'b10001, 8'hA5, 8'h3C, 1'b1, 8'h25}, // R5 flipped back, no strobe
    {4'd5, 5'b11001, 8'hA5, 8'h3C, 1'b1, 8'h25}, // R5 held across gap
    {4'd2, 5'b10011, 8'hA5, 8'h3C, 1'b0, 8'h00}, // R2 R1 oe high
    {4'd5, 5'b11001, 8'hA5, 8'h3C, 1'b1, 8'h65}, // R5
    {4'd3, 5'b01001, 8'hA5, 8'h3C, 1'b1, 8'h3C}, // R3 write done
    {4'd8, 5'b01001, 8'hA5, 8'hC3, 1'b1, 8'hC3}, // R8 idle strobe
    {4'd4, 5'b11001, 8'h00, 8'hFF, 1'b1, 8'h80}, // R4 R6 new cycle
    {4'd5, 5'b11001, 8'h00, 8'hFF, 1'b1, 8'hC0}, // R5
    {4'd1, 5'b10000, 8'h00, 8'hFF, 1'b0, 8'h00}, // R1 we low
    {4'd3, 5'b00001, 8'h00, 8'h5A, 1'b1, 8'h5A}  // R3
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s oe/data got %b/%h expected %b/%h", req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic drive(input logic b, input logic r, input logic [7:0] l, input logic [7:0] a);
    busy = b; rd = r; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; last = l; arr = a;
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R2", {oe, data}, {1'b0, 8'h00});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      {busy, rd, ce_n, oe_n, we_n, last, arr} = VEC[i][29:9];
      #1;
      chk($sformatf("R%0d", VEC[i][33:30]), {oe, data}, VEC[i][8:0]);
    end

    // R6: restart while the phase is 1
    @(negedge clk); drive(1'b1, 1'b1, 8'h11, 8'h00); #1;
    chk("R6", {oe, data}, {1'b1, 8'h91});
    @(negedge clk); drive(1'b0, 1'b0, 8'h11, 8'h77); #1;
    chk("R8", {oe, data}, {1'b1, 8'h77});
    @(negedge clk); drive(1'b1, 1'b1, 8'h11, 8'h00); #1;
    chk("R6", {oe, data}, {1'b1, 8'h91});
    @(negedge clk); drive(1'b1, 1'b0, 8'h11, 8'h00); #1;
    chk("R5", {oe, data}, {1'b1, 8'hD1});

    // R9: reset mid-cycle, busy held high
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9", {oe, data}, {1'b1, 8'h91});
    @(negedge clk); rst_n = 1'b1; drive(1'b1, 1'b1, 8'hFF, 8'h00); #1;
    chk("R9", {oe, data}, {1'b1, 8'h3F});
    @(negedge clk); drive(1'b1, 1'b1, 8'hFF, 8'h00); #1;
    chk("R5", {oe, data}, {1'b1, 8'h7F});
    @(negedge clk); drive(1'b1, 1'b0, 8'h80, 8'h00); ce_n = 1'b1; #1;
    chk("R1", {oe, data}, {1'b0, 8'h00});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule